// File: doc/BRIEF.md
# Block-Transfer DMA Controller

This controller moves a block of words between memory and an I/O device while the processor is kept off the system bus. The processor programs a start address, a word count and a transfer direction through a small register file that a two-bit select input addresses. A device then raises its request line. The controller asks the processor for the bus with a hold request. It waits for the grant, acknowledges the device and moves one word per clock until the count is used up.

Each word moves in fly-by style. The controller presents the address and asserts one read strobe and one write strobe in the same cycle: memory read with device write, or device read with memory write. The data passes straight between memory and device without going through the controller. At terminal count the controller releases the hold request and the device acknowledge together, pulses its interrupt for one cycle and sets a completion flag in the status register.

Top module: `dma_blk_ctrl`

## Requirements
- R1: After reset, hold_o, dack_o, irq_o and all four bus strobes are low, and the address, count and control registers read as zero.
- R2: While idle, a write with reg_sel_i=0 loads the address register, reg_sel_i=1 loads the count register and reg_sel_i=2 loads the direction bit (bit 0). A read with the same select returns the current value.
- R3: When dreq_i is high and the count is nonzero, hold_o rises one cycle later. No strobe and no dack_o is driven for as long as hlda_i stays low.
- R4: One cycle after hlda_i is sampled high, dack_o goes high and the bus carries the start address. The address presented grows by one on every following transfer cycle.
- R5: With direction bit 0, each transfer cycle asserts mem_rd_o and io_wr_o together. With direction bit 1, it asserts io_rd_o and mem_wr_o together. The other pair stays low in both cases.
- R6: A programmed count of N gives exactly N transfer cycles. Afterwards the count register reads 0 and the address register reads start+N.
- R7: In the cycle after the last word, irq_o is high for exactly one cycle, and hold_o and dack_o are both low in that cycle.
- R8: Status bit 1 is set at completion and cleared by a status read (reg_sel_i=2). If completion and a status read fall in the same cycle, the bit stays set.
- R9: Register writes made while a transfer is in progress (from hold request to interrupt) have no effect.
- R10: A request while the count register is zero does not raise hold_o.
- R11: Status bit 2 reads 1 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a status read clears done) |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data |
| dreq_i | input | 1 | Device transfer request |
| dack_o | output | 1 | Device acknowledge |
| hold_o | output | 1 | Bus request to the processor |
| hlda_i | input | 1 | Bus grant from the processor |
| irq_o | output | 1 | One-cycle completion interrupt |
| bus_addr_o | output | AW | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | Device read strobe |
| io_wr_o | output | 1 | Device write strobe |

## Verification
The completion flag can be set by the final transfer in the same cycle that a processor status read tries to clear it. The bench provokes this by holding a status read on the last transfer cycle of a two-word block. It then expects the flag to read as set on the following read and as clear on the read after that. A second overlap is a register write arriving during a transfer. The bench judges it by the address sequence on the bus and by the values read back once the block has finished.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_FIN  = 2'd3
  } dma_state_e;

  localparam int unsigned STAT_DIR  = 0;
  localparam int unsigned STAT_DONE = 1;
  localparam int unsigned STAT_BUSY = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_blk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          step_i,
  input  logic          fin_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          dir_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q, done_q;
  logic          wr_ok;

  assign wr_ok = wr_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
      dir_q  <= 1'b0;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      cnt_q  <= cnt_q - CW'(1);
    end else if (wr_ok) begin
      case (reg_sel_e'(sel_i))
        SEL_ADDR: addr_q <= wdata_i[AW-1:0];
        SEL_CNT:  cnt_q  <= wdata_i[CW-1:0];
        SEL_CTRL: dir_q  <= wdata_i[STAT_DIR];
        default:  ;
      endcase
    end
  end

  // completion wins over a same-cycle clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              done_q <= 1'b0;
    else if (fin_i)                           done_q <= 1'b1;
    else if (rd_i && sel_i == 2'(SEL_CTRL))   done_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (reg_sel_e'(sel_i))
      SEL_ADDR: rdata_o = DW'(addr_q);
      SEL_CNT:  rdata_o = DW'(cnt_q);
      SEL_CTRL: begin
        rdata_o[STAT_DIR]  = dir_q;
        rdata_o[STAT_DONE] = done_q;
        rdata_o[STAT_BUSY] = busy_i;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;

  a_r6_no_step_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q != '0);
  a_r6_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> cnt_q == $past(cnt_q) - CW'(1));
  a_r9_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_i && !step_i) |=> (addr_q == $past(addr_q) && cnt_q == $past(cnt_q)));
  a_r8_done_on_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_blk_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dreq_i,
  input  logic          hlda_i,
  input  logic [CW-1:0] cnt_i,
  output logic          hold_o,
  output logic          dack_o,
  output logic          step_o,
  output logic          fin_o,
  output logic          busy_o,
  output logic          irq_o
);
  dma_state_e st_q, st_d;
  logic       last;

  assign last = (cnt_i == CW'(1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (dreq_i && cnt_i != '0) st_d = ST_REQ;
      ST_REQ:  if (hlda_i)                st_d = ST_XFER;
      ST_XFER: if (last)                  st_d = ST_FIN;
      ST_FIN:                             st_d = ST_IDLE;
      default:                            st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign hold_o = (st_q == ST_REQ) || (st_q == ST_XFER);
  assign dack_o = (st_q == ST_XFER);
  assign step_o = (st_q == ST_XFER);
  assign fin_o  = (st_q == ST_XFER) && last;
  assign busy_o = (st_q != ST_IDLE);
  assign irq_o  = (st_q == ST_FIN);

  a_r3_master_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> $past(hlda_i));
  a_r7_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  a_r10_no_hold_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cnt_i == '0) |=> !hold_o);
endmodule

// File: rtl/dma_blk_ctrl.sv
module dma_blk_ctrl
  import dma_blk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          dreq_i,
  output logic          dack_o,
  output logic          hold_o,
  input  logic          hlda_i,
  output logic          irq_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          io_rd_o,
  output logic          io_wr_o
);
  logic [CW-1:0] cnt;
  logic          dir, step, fin, busy;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (reg_sel_i),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .wdata_i (reg_wdata_i),
    .busy_i  (busy),
    .step_i  (step),
    .fin_i   (fin),
    .addr_o  (bus_addr_o),
    .cnt_o   (cnt),
    .dir_o   (dir),
    .rdata_o (reg_rdata_o)
  );

  dma_seq #(.CW(CW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dreq_i (dreq_i),
    .hlda_i (hlda_i),
    .cnt_i  (cnt),
    .hold_o (hold_o),
    .dack_o (dack_o),
    .step_o (step),
    .fin_o  (fin),
    .busy_o (busy),
    .irq_o  (irq_o)
  );

  // fly-by: one read and one write strobe per word
  assign mem_rd_o = step && !dir;
  assign io_wr_o  = step && !dir;
  assign io_rd_o  = step && dir;
  assign mem_wr_o = step && dir;

  a_r3_strobe_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || io_rd_o || io_wr_o) |-> (hold_o && dack_o));
  a_r5_one_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((mem_rd_o || io_wr_o) && (io_rd_o || mem_wr_o)));
  a_r4_addr_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && $past(dack_o)) |-> bus_addr_o == $past(bus_addr_o) + AW'(1));
  a_r7_bus_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!hold_o && !dack_o));
endmodule

// File: tb/tb_dma_blk_ctrl.sv
module tb_dma_blk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;

  // {start[28:13], count[12:5], dir[4], grant delay[3:0]}
  localparam int NV = 4;
  localparam logic [28:0] VEC [NV] = '{
    {16'h0100, 8'd4, 1'b0, 4'd0},
    {16'h2000, 8'd1, 1'b1, 4'd2},
    {16'hfffe, 8'd5, 1'b0, 4'd1},
    {16'h0a00, 8'd7, 1'b1, 4'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sel = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          dreq = 1'b0, hlda = 1'b0;
  logic          dack, hold, irq, mrd, mwr, ird, iwr;
  logic [AW-1:0] addr;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_blk_ctrl #(.AW(AW), .CW(CW), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .dreq_i(dreq), .dack_o(dack), .hold_o(hold), .hlda_i(hlda),
    .irq_o(irq), .bus_addr_o(addr),
    .mem_rd_o(mrd), .mem_wr_o(mwr), .io_rd_o(ird), .io_wr_o(iwr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [DW-1:0] d);
    @(negedge clk); sel = s; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [3:0] strobes();
    return {mrd, iwr, ird, mwr};
  endfunction

  task automatic run_xfer(input logic [15:0] st, input int n, input logic dir, input int lat);
    logic [DW-1:0] v;
    wr_reg(2'd0, st);
    wr_reg(2'd1, DW'(n));
    wr_reg(2'd2, DW'(dir));
    rd_reg(2'd0, v); chk(v == st, "R2 addr readback", v, st);
    rd_reg(2'd1, v); chk(v == DW'(n), "R2 count readback", v, n);
    rd_reg(2'd2, v); chk(v[0] == dir, "R2 dir readback", v, dir);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk);
    chk(hold == 1'b1, "R3 hold raised", hold, 1);
    chk(dack == 1'b0 && strobes() == 4'b0, "R3 idle before grant", {dack, strobes()}, 0);
    for (int w = 0; w < lat; w++) begin
      @(negedge clk);
      chk(strobes() == 4'b0 && dack == 1'b0 && hold, "R3 wait grant", {hold, dack, strobes()}, 5'b10000);
    end
    hlda = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dack && hold, "R4 master", {hold, dack}, 2'b11);
      chk(addr == AW'(st + 16'(i)), "R4 address", addr, st + 16'(i));
      chk(strobes() == (dir ? 4'b0011 : 4'b1100), "R5 strobe pair", strobes(), dir ? 4'b0011 : 4'b1100);
      chk(irq == 1'b0, "R6 no early irq", irq, 0);
    end
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq", irq, 1);
    chk(!hold && !dack && strobes() == 4'b0, "R7 release", {hold, dack, strobes()}, 0);
    dreq = 1'b0; hlda = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq single", irq, 0);
    rd_reg(2'd1, v); chk(v == '0, "R6 count zero", v, 0);
    rd_reg(2'd0, v); chk(v == DW'(st + 16'(n)), "R6 end addr", v, st + 16'(n));
    rd_reg(2'd2, v); chk(v[1] == 1'b1, "R8 done set", v, 2);
    rd_reg(2'd2, v); chk(v[1] == 1'b0, "R8 done cleared", v[1], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hold, dack, irq, strobes()} == '0, "R1 outputs idle", {hold, dack, irq, strobes()}, 0);
    rd_reg(2'd0, v); chk(v == '0, "R1 addr reset", v, 0);
    rd_reg(2'd1, v); chk(v == '0, "R1 count reset", v, 0);
    rd_reg(2'd2, v); chk(v == '0, "R1 status reset", v, 0);

    // R10: request with zero count
    @(negedge clk); dreq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(hold == 1'b0, "R10 no hold at zero count", hold, 0);
    end
    dreq = 1'b0;

    for (int e = 0; e < NV; e++)
      run_xfer(VEC[e][28:13], int'(VEC[e][12:5]), VEC[e][4], int'(VEC[e][3:0]));

    // R9: writes during a transfer are ignored
    wr_reg(2'd0, 16'h0040);
    wr_reg(2'd1, 16'd3);
    wr_reg(2'd2, 16'd0);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); hlda = 1'b1;
    sel = 2'd0; wdata = 16'hffff; wr = 1'b1;
    @(negedge clk);
    sel = 2'd1; wdata = 16'd9;
    chk(addr == 16'h0040, "R9 addr kept", addr, 16'h0040);
    @(negedge clk);
    sel = 2'd2; wdata = 16'd1;
    chk(addr == 16'h0041 && mrd, "R9 walk kept", {mrd, addr}, {1'b1, 16'h0041});
    @(negedge clk);
    wr = 1'b0;
    chk(addr == 16'h0042 && mrd && !ird, "R9 dir kept", {mrd, ird, addr}, {2'b10, 16'h0042});
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq after three words", irq, 1);
    dreq = 1'b0; hlda = 1'b0;
    rd_reg(2'd0, v); chk(v == 16'h0043, "R9 addr after block", v, 16'h0043);
    rd_reg(2'd1, v); chk(v == '0, "R9 count after block", v, 0);
    rd_reg(2'd2, v); chk(v[0] == 1'b0, "R9 dir unchanged", v[0], 0);

    // R8/R11: status read coinciding with completion
    wr_reg(2'd0, 16'h0080);
    wr_reg(2'd1, 16'd2);
    wr_reg(2'd2, 16'd1);
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); hlda = 1'b1;
    sel = 2'd2; #1;
    chk(rdata[2] == 1'b1, "R11 busy while holding", rdata[2], 1);
    @(negedge clk);
    chk(ird && mwr && !mrd && !iwr, "R5 device to memory", strobes(), 4'b0011);
    @(negedge clk);
    sel = 2'd2; rd = 1'b1; #1;
    chk(rdata[2] == 1'b1, "R11 busy in transfer", rdata[2], 1);
    @(negedge clk);
    rd = 1'b0;
    chk(irq == 1'b1, "R7 irq on overlap", irq, 1);
    dreq = 1'b0; hlda = 1'b0;
    rd_reg(2'd2, v); chk(v[1] == 1'b1, "R8 set wins over read", v[1], 1);
    chk(v[2] == 1'b0, "R11 busy clear after", v[2], 0);
    rd_reg(2'd2, v); chk(v[1] == 1'b0, "R8 cleared by read", v[1], 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule